// File: doc/BRIEF.md
# Voltage ADC Control and Result Register Front End

This block is the register-level face of a 12-bit voltage converter. A processor reaches it over a simple 8-bit bus with an address, a write strobe and a combinational read path. Through a single control/status byte the processor enables the converter, requests a conversion, watches a busy indication and manages a completion interrupt. The block turns an accepted request into a one-cycle start pulse toward an abstract converter core. It waits for that core's done strobe, then latches the 12-bit sample into a pair of read-only result bytes.

Completion raises a sticky flag. The flag drives an interrupt request when both its local enable and a global interrupt enable are high. The flag is cleared either by the interrupt controller's acknowledge strobe or by software writing a one to it. Alongside the raw sample, the block presents a corrected value. The offset input is subtracted from the held sample with a floor at zero, the difference is scaled by the gain input, and the product is divided by 2^14.

Top module: `adc_ctrl_regs`

## Requirements
- R1: A write to the control byte (address 0x7A) with bit 3 (enable) and bit 2 (start) both one, while idle, produces a single-cycle `convStart` pulse in the cycle after the write. From then on bit 2 reads one until the conversion ends. A write with bit 2 zero leaves the busy state unchanged.
- R2: A start request written while a conversion is already busy produces no `convStart` pulse, and the block stays busy.
- R3: A control write with bit 3 zero clears the busy bit at once. A `convDone` arriving while not busy changes neither the result nor the flag.
- R4: `convDone` while busy captures `convData` into the result, sets the flag (bit 1) and clears busy, all on the same clock edge.
- R5: The flag is cleared by a control write with bit 1 set, or by `intAck`. A control write with bit 1 zero leaves the flag unchanged. A completion in the same cycle as a clear leaves the flag set.
- R6: `irq` is high exactly when the flag, the interrupt enable (control bit 0) and `globalIntEn` are all one.
- R7: Result bits 7:0 read at address 0x78 and bits 11:8 read at address 0x79 in its low nibble, with the upper nibble zero. Control bits 7:4 read zero. Bus writes to 0x78 and 0x79 have no effect.
- R8: `calOut` equals floor(max(0, result - calOffset) * calGain / 16384), computed from the held result.
- R9: After reset the control byte, both result bytes, `irq` and `convStart` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| globalIntEn | input | 1 | Processor-wide interrupt enable |
| intAck | input | 1 | Interrupt vector acknowledge, clears the flag |
| convStart | output | 1 | One-cycle start pulse to the converter core |
| convDone | input | 1 | Converter finished, convData valid |
| convData | input | 12 | Converted sample |
| irq | output | 1 | Completion interrupt request |
| calOffset | input | 12 | Offset calibration word |
| calGain | input | 16 | Gain calibration word (16384 = unity) |
| calOut | output | 14 | Offset- and gain-corrected result |

## Verification
The assertions assume that the converter core raises `convDone` only for a single cycle, and that a done strobe outside a busy period is meaningless and may be dropped. They also assume that bus writes are single-cycle strobes. The stimulus asserts `convDone` for one cycle, a few cycles after each start pulse, except in the deliberate test of a done strobe after an abort. It holds the calibration words steady from the completion until the corrected value has been checked. Same-cycle collisions of completion with acknowledge are produced on purpose, aligned to the falling edge, so that the priority can be observed.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capture;   // latch converter data into the result register
  } ctrl_strobe_t;

  // Control byte bit positions
  localparam int BIT_EN    = 3;
  localparam int BIT_START = 2;
  localparam int BIT_FLAG  = 1;
  localparam int BIT_IE    = 0;
endpackage

// File: rtl/adc_ctrl_fsm.sv
module adc_ctrl_fsm
  import adc_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csrWr,
  input  logic [3:0]   csrWdata,
  input  logic         convDone,
  input  logic         intAck,
  output logic         enQ,
  output logic         busyQ,
  output logic         flagQ,
  output logic         ieQ,
  output logic         convStart,
  output ctrl_strobe_t strobe
);
  logic startReq;
  logic disableWr;
  logic flagClr;
  logic convStartQ;

  assign disableWr = csrWr && !csrWdata[BIT_EN];
  assign startReq  = csrWr && csrWdata[BIT_START] && csrWdata[BIT_EN] && !busyQ;
  assign flagClr   = intAck || (csrWr && csrWdata[BIT_FLAG]);
  assign strobe.capture = busyQ && convDone;
  assign convStart = convStartQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      ieQ        <= 1'b0;
      busyQ      <= 1'b0;
      flagQ      <= 1'b0;
      convStartQ <= 1'b0;
    end else begin
      convStartQ <= startReq;
      if (csrWr) begin
        enQ <= csrWdata[BIT_EN];
        ieQ <= csrWdata[BIT_IE];
      end
      if (disableWr)           busyQ <= 1'b0;
      else if (startReq)       busyQ <= 1'b1;
      else if (strobe.capture) busyQ <= 1'b0;
      if (strobe.capture)      flagQ <= 1'b1;
      else if (flagClr)        flagQ <= 1'b0;
    end
  end

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWr && busyQ && !disableWr) |=> (!convStart && busyQ));
  // R3
  disable_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    disableWr |=> !busyQ);
  // R4
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && convDone) |=> (flagQ && !busyQ));
  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(busyQ && convDone));
endmodule

// File: rtl/adc_ctrl_datapath.sv
module adc_ctrl_datapath
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int GAIN_W    = 16,
  parameter int CAL_SHIFT = 14,
  parameter bit CAL_EN    = 1'b1,
  localparam int CAL_W    = RES_W + GAIN_W - CAL_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [RES_W-1:0]  convData,
  input  logic [RES_W-1:0]  calOffset,
  input  logic [GAIN_W-1:0] calGain,
  output logic [RES_W-1:0]  result,
  output logic [CAL_W-1:0]  calOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= convData;
  end

  generate
    if (CAL_EN) begin : g_cal
      logic signed [RES_W:0]     diff;
      logic [RES_W-1:0]          diffPos;
      logic [RES_W+GAIN_W-1:0]   product;
      assign diff    = $signed({1'b0, result}) - $signed({1'b0, calOffset});
      assign diffPos = diff[RES_W] ? '0 : diff[RES_W-1:0];
      assign product = {{GAIN_W{1'b0}}, diffPos} * {{RES_W{1'b0}}, calGain};
      assign calOut  = product[RES_W+GAIN_W-1:CAL_SHIFT];
    end else begin : g_nocal
      assign calOut = '0;
    end
  endgenerate

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(result));
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int          RES_W     = 12,
  parameter int          GAIN_W    = 16,
  parameter int          CAL_SHIFT = 14,
  parameter bit          CAL_EN    = 1'b1,
  parameter logic [7:0]  CSR_ADDR  = 8'h7A,
  parameter logic [7:0]  RESL_ADDR = 8'h78,
  parameter logic [7:0]  RESH_ADDR = 8'h79,
  localparam int         CAL_W     = RES_W + GAIN_W - CAL_SHIFT,
  localparam int         HI_W      = RES_W - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              globalIntEn,
  input  logic              intAck,
  output logic              convStart,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  output logic              irq,
  input  logic [RES_W-1:0]  calOffset,
  input  logic [GAIN_W-1:0] calGain,
  output logic [CAL_W-1:0]  calOut
);
  ctrl_strobe_t     strobe;
  logic             csrWr;
  logic             enQ, busyQ, flagQ, ieQ;
  logic [RES_W-1:0] result;

  assign csrWr = busWrEn && (busAddr == CSR_ADDR);

  adc_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .csrWr(csrWr), .csrWdata(busWdata[3:0]),
    .convDone(convDone), .intAck(intAck),
    .enQ(enQ), .busyQ(busyQ), .flagQ(flagQ), .ieQ(ieQ),
    .convStart(convStart), .strobe(strobe)
  );

  adc_ctrl_datapath #(
    .RES_W(RES_W), .GAIN_W(GAIN_W), .CAL_SHIFT(CAL_SHIFT), .CAL_EN(CAL_EN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convData(convData),
    .calOffset(calOffset), .calGain(calGain),
    .result(result), .calOut(calOut)
  );

  assign irq = flagQ && ieQ && globalIntEn;

  always_comb begin
    busRdata = 8'h00;
    if (busAddr == CSR_ADDR)
      busRdata = {4'b0000, enQ, busyQ, flagQ, ieQ};
    else if (busAddr == RESL_ADDR)
      busRdata = result[7:0];
    else if (busAddr == RESH_ADDR)
      busRdata = {{(8-HI_W){1'b0}}, result[RES_W-1:8]};
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq |-> globalIntEn) and ($fell(flagQ) |-> !irq));
endmodule

// File: tb/adc_ctrl_regs_test.sv
module adc_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  busRdata;
  logic        globalIntEn = 1'b0;
  logic        intAck = 1'b0;
  logic        convStart;
  logic        convDone = 1'b0;
  logic [11:0] convData = 12'h000;
  logic        irq;
  logic [11:0] calOffset = 12'h000;
  logic [15:0] calGain = 16'h4000;
  logic [13:0] calOut;

  int checks = 0;
  int errors = 0;
  int startPulses = 0;
  bit sbOn = 1'b0;
  bit prevIrq = 1'b0;
  bit finished = 1'b0;
  int expQ[$];
  logic [7:0] rv;

  always #5 clk = ~clk;

  adc_ctrl_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .globalIntEn(globalIntEn),
    .intAck(intAck), .convStart(convStart), .convDone(convDone),
    .convData(convData), .irq(irq), .calOffset(calOffset),
    .calGain(calGain), .calOut(calOut)
  );

  always @(posedge clk) if (convStart) startPulses <= startPulses + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic done(input logic [11:0] data, input bit ack);
    @(negedge clk);
    convDone = 1'b1; convData = data; intAck = ack;
    @(negedge clk);
    convDone = 1'b0; intAck = 1'b0;
  endtask

  function automatic int calExp(int raw, int off, int gain);
    longint d = raw - off;
    if (d < 0) return 0;
    return int'((d * gain) >> 14);
  endfunction

  // Scoreboard driver: push expected corrected value, run a conversion
  task automatic convert(input int raw, input int off, input int gain);
    calOffset = off[11:0]; calGain = gain[15:0];
    expQ.push_back(calExp(raw, off, gain));
    wr(8'h7A, 8'h0D);
    @(negedge clk);
    done(raw[11:0], 1'b0);
    @(negedge clk);
    wr(8'h7A, 8'h0B);
  endtask

  // Scoreboard monitor: on each irq rise compare corrected output
  always @(negedge clk) begin
    if (sbOn && irq && !prevIrq) begin
      if (expQ.size() == 0) check("R6 unexpected irq", 1, 0);
      else check("R8 calOut", int'(calOut), expQ.pop_front());
    end
    prevIrq <= irq;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    rd(8'h7A, rv); check("R9 csr", rv, 8'h00);
    rd(8'h78, rv); check("R9 resL", rv, 8'h00);
    rd(8'h79, rv); check("R9 resH", rv, 8'h00);
    check("R9 irq", irq, 0);
    check("R9 convStart", convStart, 0);

    globalIntEn = 1'b1;
    // R1 start pulse and busy
    wr(8'h7A, 8'h0C);
    check("R1 convStart pulse", convStart, 1);
    rd(8'h7A, rv); check("R1 busy set", rv, 8'h0C);
    @(negedge clk);
    check("R1 pulse ends", convStart, 0);
    // R2 start while busy
    wr(8'h7A, 8'h0C);
    @(negedge clk);
    check("R2 no second pulse", startPulses, 1);
    rd(8'h7A, rv); check("R2 still busy", rv, 8'h0C);
    // R1 writing start zero has no effect
    wr(8'h7A, 8'h08);
    rd(8'h7A, rv); check("R1 zero start no effect", rv, 8'h0C);
    // R4 completion
    done(12'hABC, 1'b0);
    rd(8'h7A, rv); check("R4 flag set busy clear", rv, 8'h0A);
    rd(8'h78, rv); check("R7 resL", rv, 8'hBC);
    rd(8'h79, rv); check("R7 resH", rv, 8'h0A);
    check("R6 irq off with ie=0", irq, 0);
    // R7 result read only
    wr(8'h78, 8'h55);
    wr(8'h79, 8'hFF);
    rd(8'h78, rv); check("R7 resL write ignored", rv, 8'hBC);
    rd(8'h79, rv); check("R7 resH write ignored", rv, 8'h0A);
    // R5 write zero to flag keeps it; R6 irq gating
    wr(8'h7A, 8'h09);
    rd(8'h7A, rv); check("R5 flag kept", rv, 8'h0B);
    check("R6 irq on", irq, 1);
    globalIntEn = 1'b0;
    #1 check("R6 irq off with gie=0", irq, 0);
    globalIntEn = 1'b1;
    // R5 write one clears
    wr(8'h7A, 8'h0B);
    rd(8'h7A, rv); check("R5 w1c", rv, 8'h09);
    check("R5 irq after w1c", irq, 0);
    // R5 acknowledge clears
    wr(8'h7A, 8'h0D);
    @(negedge clk);
    done(12'h123, 1'b0);
    check("R6 irq on completion", irq, 1);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    rd(8'h7A, rv); check("R5 ack clears", rv, 8'h09);
    // R5 set wins over ack
    wr(8'h7A, 8'h0D);
    @(negedge clk);
    done(12'h456, 1'b1);
    rd(8'h7A, rv); check("R5 set wins", rv, 8'h0B);
    wr(8'h7A, 8'h0B);
    // R3 disable clears busy, stray done ignored
    wr(8'h7A, 8'h0D);
    wr(8'h7A, 8'h01);
    rd(8'h7A, rv); check("R3 busy cleared", rv, 8'h01);
    done(12'h777, 1'b0);
    rd(8'h78, rv); check("R3 result kept", rv, 8'h56);
    rd(8'h7A, rv); check("R3 flag not set", rv, 8'h01);
    // R8 scoreboard of corrected values
    @(negedge clk);
    sbOn = 1'b1;
    convert(12'h800, 12'h010, 16'h4000);
    convert(100, 200, 16'h5000);
    convert(12'hFFF, 0, 16'hFFFF);
    convert(50, 50, 16'h8000);
    convert(12'h3E8, 12'h064, 16'h3000);
    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule